// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block multiplies two register operands over a fixed number of clock cycles and returns the least significant word of the product. It can also add a third operand, an accumulator, to that product. The unit consumes a small group of multiplier bits on each cycle, so one shared adder replaces a full array multiplier. The upper half of the double-width product is never formed. The kept word is the same whether the operands are read as signed or as unsigned values.

A caller presents both operands, the accumulator, the accumulate enable, the set-flags request and the current condition flags, then pulses `start` while the unit is idle. All of these inputs are captured on that edge. `busy` stays high while the product is built. `done` then pulses for one cycle, with `result` and `flags_out` valid. Both outputs hold until the next accepted start. When flags are requested, N and Z follow the result, C is forced to 0 and V keeps its incoming value. Without the request, the captured flags pass through unchanged.

Top module: `seq_mac_unit`

## Requirements
- R1: `result` equals bits [WIDTH-1:0] of `op_a * op_b` when `acc_en` is 0. Higher product bits are discarded.
- R2: `result` equals the low word of the product of the operands read as two's-complement signed values.
- R3: When `acc_en` is 1, `result` equals bits [WIDTH-1:0] of `op_a * op_b + acc_in`.
- R4: `flags_out` is packed as {N,Z,C,V} in bits 3..0. When `set_flags` is 1, N equals result bit WIDTH-1, and Z is 1 exactly when the result is zero.
- R5: When `set_flags` is 1, bit 0 (V) of `flags_out` equals bit 0 of the captured `flags_in`, and bit 1 (C) is 0.
- R6: When `set_flags` is 0, `flags_out` equals the `flags_in` value captured at start.
- R7: `done` rises exactly WIDTH/DIGIT clock edges after the edge that accepts `start` (16 at defaults). It stays high for exactly one cycle, and `busy` is high from the accepting edge until `done` rises.
- R8: A `start` pulse while `busy` is high is ignored. It does not change the result, the latency or the operands in use.
- R9: A synchronous reset clears `busy`, `done`, `result`, `flags_out` and the internal partial product.
- R10: `result` and `flags_out` hold their values while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; accepted only while idle |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier register value |
| acc_in | input | WIDTH | Accumulator added when acc_en is high |
| acc_en | input | 1 | Select multiply-accumulate |
| set_flags | input | 1 | Request flag update from the result |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Low word of product (plus accumulator) |
| flags_out | output | 4 | Updated flags {N,Z,C,V} |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a run. It must change neither the operands being shifted nor the step count. The bench drives this pulse partway through an operation, with inverted operands and the opposite modes. It then checks that the result, the flags and the 16-cycle latency still match the first request. The sweep crosses eight corner operands: zero, one, all-ones, the sign bit alone, the largest positive value and mixed patterns. Each pair is run in all four combinations of accumulate and set-flags, so wrap-around, negative results and zero results all occur.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/mac_digit_step.sv
module mac_digit_step #(
    parameter int W = 32,
    parameter int D = 2
) (
    input  logic [W-1:0] pp,
    input  logic [W-1:0] a_sh,
    input  logic [D-1:0] digit,
    output logic [W-1:0] pp_nxt
);
    logic [W-1:0] terms [D];

    for (genvar gi = 0; gi < D; gi++) begin : g_term
        assign terms[gi] = digit[gi] ? (a_sh << gi) : '0;
    end

    always_comb begin
        pp_nxt = pp;
        for (int k = 0; k < D; k++) begin
            pp_nxt = pp_nxt + terms[k];
        end
    end
endmodule

// File: rtl/mac_flag_unit.sv
module mac_flag_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0]     value,
    input  logic             upd,
    input  mac_pkg::flags_t  fin,
    output mac_pkg::flags_t  fout
);
    always_comb begin
        fout = fin;
        if (upd) begin
            fout.n = value[W-1];
            fout.z = (value == '0);
            fout.c = 1'b0;
            fout.v = fin.v;
        end
    end
endmodule

// File: rtl/seq_mac_unit.sv
module seq_mac_unit #(
    parameter int WIDTH = 32,
    parameter int DIGIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] acc_in,
    input  logic             acc_en,
    input  logic             set_flags,
    input  logic [3:0]       flags_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags_out
);
    import mac_pkg::*;

    localparam int STEPS = WIDTH / DIGIT;
    localparam int CW    = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        phase_e           phase;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] a_sh;
        logic [WIDTH-1:0] b_sh;
        logic [WIDTH-1:0] pp;
        logic [WIDTH-1:0] res;
        logic             sf;
        flags_t           fin;
        flags_t           fout;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] step_pp;
    flags_t           step_flags;

    mac_digit_step #(.W(WIDTH), .D(DIGIT)) u_step (
        .pp     (st_q.pp),
        .a_sh   (st_q.a_sh),
        .digit  (st_q.b_sh[DIGIT-1:0]),
        .pp_nxt (step_pp)
    );

    mac_flag_unit #(.W(WIDTH)) u_flags (
        .value (step_pp),
        .upd   (st_q.sf),
        .fin   (st_q.fin),
        .fout  (step_flags)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                    st_d.a_sh  = op_a;
                    st_d.b_sh  = op_b;
                    st_d.pp    = acc_en ? acc_in : '0;
                    st_d.sf    = set_flags;
                    st_d.fin   = flags_t'(flags_in);
                end
            end
            PH_RUN: begin
                st_d.pp   = step_pp;
                st_d.a_sh = st_q.a_sh << DIGIT;
                st_d.b_sh = st_q.b_sh >> DIGIT;
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.res   = step_pp;
                    st_d.fout  = step_flags;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase == PH_RUN);
    assign done      = st_q.done;
    assign result    = st_q.res;
    assign flags_out = st_q.fout;
endmodule

// File: rtl/seq_mac_unit_chk.sv
module seq_mac_unit_chk #(
    parameter int WIDTH = 32,
    parameter int STEPS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             set_flags,
    input logic [3:0]       flags_in,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       flags_out
);
    localparam int CW = $clog2(STEPS + 2);

    logic          sf_cap;
    logic          v_cap;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sf_cap  <= 1'b0;
            v_cap   <= 1'b0;
            run_cnt <= '0;
        end else if (start && !busy) begin
            sf_cap  <= set_flags;
            v_cap   <= flags_in[0];
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r8_latency_kept: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == CW'(STEPS)));

    a_r5_flag_rule: assert property (@(posedge clk) disable iff (rst)
        (done && sf_cap) |-> (flags_out[1] == 1'b0 && flags_out[0] == v_cap));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(result) && $stable(flags_out)));

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!busy && !done && result == '0 && flags_out == 4'd0));
endmodule

bind seq_mac_unit seq_mac_unit_chk #(.WIDTH(WIDTH), .STEPS(WIDTH / DIGIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .set_flags (set_flags),
    .flags_in  (flags_in),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/seq_mac_unit_test.sv
module seq_mac_unit_test;
    localparam int W = 32;
    localparam int LAT = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] op_a, op_b, acc_in;
    logic         acc_en, set_flags;
    logic [3:0]   flags_in;
    logic         busy, done;
    logic [W-1:0] result;
    logic [3:0]   flags_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seq_mac_unit #(.WIDTH(W), .DIGIT(2)) uut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .acc_en(acc_en), .set_flags(set_flags),
        .flags_in(flags_in), .busy(busy), .done(done), .result(result),
        .flags_out(flags_out)
    );

    localparam logic [W-1:0] VALS [8] = '{
        32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
        32'h7FFF_FFFF, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0000_0003
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] acc, input bit en, input bit sf,
                          input logic [3:0] fl, input bit inject);
        logic [63:0] full;
        logic signed [63:0] sfull;
        logic [W-1:0] exp_r;
        logic [3:0]   exp_f;
        int n;
        full  = {32'b0, a} * {32'b0, b};
        sfull = $signed({{32{a[W-1]}}, a}) * $signed({{32{b[W-1]}}, b});
        exp_r = full[W-1:0] + (en ? acc : '0);
        if (sf) exp_f = {exp_r[W-1], exp_r == '0, 1'b0, fl[0]};
        else    exp_f = fl;

        @(negedge clk);
        op_a = a; op_b = b; acc_in = acc; acc_en = en;
        set_flags = sf; flags_in = fl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = ~a; op_b = ~b; acc_in = ~acc; flags_in = ~fl;
        chk(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (inject && n == 5) begin
                start = 1'b1; acc_en = ~en; set_flags = ~sf;
            end
            if (inject && n == 6) start = 1'b0;
        end
        chk(n == LAT, inject ? "R8 latency under restart" : "R7 latency",
            64'(n), 64'(LAT));
        chk(result == exp_r, inject ? "R8 result under restart" :
            (en ? "R3 accumulate result" : "R1 product low word"),
            64'(result), 64'(exp_r));
        if (!en)
            chk(result == sfull[W-1:0], "R2 signed view", 64'(result),
                64'(sfull[W-1:0]));
        chk(flags_out == exp_f, sf ? "R4/R5 flags set" : "R6 flags passed",
            64'(flags_out), 64'(exp_f));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 done one cycle",
            64'({busy, done}), 64'd0);
        chk(result == exp_r && flags_out == exp_f, "R10 hold while idle",
            64'(result), 64'(exp_r));
        start = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; acc_in = '0;
        acc_en = 1'b0; set_flags = 1'b0; flags_in = '0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && result == 0 && flags_out == 0,
            "R9 reset state", 64'({busy, done, flags_out}), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int m = 0; m < 4; m++) begin
                    run_op(VALS[i], VALS[j], VALS[(i + j + m) % 8] ^ 32'h0F0F_1234,
                           m[0], m[1], 4'(i * 3 + j + m), 1'b0);
                end
            end
        end

        run_op(32'h0001_0003, 32'h0002_0005, 32'h0000_0010, 1'b1, 1'b1, 4'b0011, 1'b1);
        run_op(32'hFFFF_FFFE, 32'h0000_0007, 32'h0, 1'b0, 1'b0, 4'b1010, 1'b1);
        run_op(32'h0000_0002, 32'h8000_0000, 32'h0, 1'b0, 1'b1, 4'b0001, 1'b0);
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1, 4'b0110, 1'b0);

        @(negedge clk);
        rst = 1'b1;
        op_a = 32'h3; op_b = 32'h5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk(busy == 0 && done == 0 && result == 0 && flags_out == 0,
            "R9 reset after run", 64'(result), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule